// File: doc/BRIEF.md
# Prescaled auto-reload timer

A general-purpose counter for a bus-clocked subsystem. A programmable divider sets how often the counter moves: it advances once every (prescale + 1) clocks, so with a 48 MHz clock a prescale of 47 gives a 1 MHz rate. The counter can count up or down. When it reaches its end value it can either restart on its own or stop. It raises a sticky event flag and an interrupt output that can be masked.

Software programs a control word, a preload word and a prescale value, then reads the live count. A common setup is a free-running up-counter with the preload at all ones. Such a counter wraps from the maximum value to zero, so the unsigned difference between two reads of the count gives the elapsed time, and it stays correct across a wrap. The interrupt can stay masked while the counter runs. A soft-reset bit in the control word returns every register to its default.

Top module: `pre_timer`

## Requirements
- R1: After rst_ni is released, count_o, ctrl_o and preload_o are all zero, and flag_o and irq_o are low.
- R2: While control bit 0 (enable) and bit 1 (start) are both set, the count moves by one step every (P+1) clocks, where P is the prescale field in control bits [16+PSC_W-1:16]. In up mode, the count n clocks after the start write is floor(n/(P+1)), until it reaches its end value.
- R3: A control write that changes bit 1 from 0 to 1 loads the count and restarts the divider phase. The count is loaded with zero when bit 2 (up) is set in that write, and with the preload value when it is clear. A write that leaves bit 1 at 1 does not reload.
- R4: In up mode with bit 3 (auto) set, a step taken when the count equals the preload returns the count to zero and sets flag_o. With the preload at all ones this forms a free-running counter that wraps.
- R5: In up mode with auto clear, a step taken when the count equals the preload holds the count, clears control bit 1 and sets flag_o.
- R6: In down mode the count decrements. With auto set, a step taken at zero reloads the preload and sets flag_o. With auto clear, a step taken at zero holds the count at zero, clears bit 1 and sets flag_o.
- R7: Clearing enable freezes both the count and the divider phase. Setting enable again resumes counting from the same phase.
- R8: A control write with bit 5 set clears the control word, preload, count and flag, whatever the other bits hold. ctrl_o shows bit 5 set for exactly one cycle, then reads zero.
- R9: irq_o is high only while flag_o is high and control bit 4 (interrupt enable) is set. flag_o stays set until a flag_clr_i pulse, and the counter runs the same whether bit 4 is set or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Write strobe for the control word |
| preload_we_i | input | 1 | Write strobe for the preload |
| wdata_i | input | 32 | Write data; the preload takes bits [CNT_W-1:0] |
| flag_clr_i | input | 1 | Clears the event flag |
| ctrl_o | output | 32 | Control word readback |
| preload_o | output | CNT_W | Preload readback |
| count_o | output | CNT_W | Live count |
| flag_o | output | 1 | Sticky end-of-count event |
| irq_o | output | 1 | Event flag gated by interrupt enable |

## Verification
The bench builds the block with CNT_W = 8 and PSC_W = 8. With an 8-bit count, a wrap from the all-ones preload takes only 256 steps, so the wrap and the free-running difference behaviour can be checked cycle by cycle. The full prescale range is kept, so the 47 setting runs at its true ratio. Every clock, the bench checks the count, the event flag and the start bit against closed-form expressions in the elapsed cycle count. It does this for prescale values 0, 1, 2 and 47, for both directions with and without auto-restart, and for preload values from 0 up to all ones.

// File: rtl/pre_timer_pkg.sv
package pre_timer_pkg;
  localparam int unsigned CTRL_W    = 32;
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_START = 1;
  localparam int unsigned BIT_UP    = 2;
  localparam int unsigned BIT_AUTO  = 3;
  localparam int unsigned BIT_IRQ   = 4;
  localparam int unsigned BIT_SRST  = 5;
  localparam int unsigned PSC_LSB   = 16;
endpackage

// File: rtl/pre_timer_div.sv
module pre_timer_div #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] phase_q;

  // >= keeps the period bounded if the prescale shrinks mid-run
  assign tick_o = run_i && (phase_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (clr_i)  phase_q <= '0;
    else if (tick_o) phase_q <= '0;
    else if (run_i)  phase_q <= phase_q + PSC_W'(1);
  end
endmodule

// File: rtl/pre_timer_cnt.sv
module pre_timer_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             load_up_i,
  input  logic             tick_i,
  input  logic             up_i,
  input  logic             auto_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             at_end;

  assign at_end  = up_i ? (count_q == preload_i) : (count_q == '0);
  assign hit_o   = tick_i && at_end && !load_i && !clr_i;
  assign count_o = count_q;

  always_comb begin
    count_d = count_q;
    if (clr_i)        count_d = '0;
    else if (load_i)  count_d = load_up_i ? '0 : preload_i;
    else if (tick_i) begin
      if (at_end) begin
        if (auto_i) count_d = up_i ? '0 : preload_i;
      end else begin
        count_d = up_i ? count_q + CNT_W'(1) : count_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end
endmodule

// File: rtl/pre_timer.sv
module pre_timer
  import pre_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PSC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              preload_we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              flag_clr_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  preload_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              flag_o,
  output logic              irq_o
);
  localparam logic [CTRL_W-1:0] LOW_MASK  = CTRL_W'(32'h1f);
  localparam logic [CTRL_W-1:0] PSC_MASK  = CTRL_W'((1 << PSC_W) - 1) << PSC_LSB;
  localparam logic [CTRL_W-1:0] KEEP_MASK = LOW_MASK | PSC_MASK;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  preload_q;
  logic              srst_q, flag_q;
  logic              srst_wr, start_rise, run, tick, hit;

  assign srst_wr    = ctrl_we_i && wdata_i[BIT_SRST];
  assign start_rise = ctrl_we_i && !srst_wr && wdata_i[BIT_START] && !ctrl_q[BIT_START];
  assign run        = ctrl_q[BIT_EN] && ctrl_q[BIT_START];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      preload_q <= '0;
      srst_q    <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      srst_q <= srst_wr;
      if (srst_wr)                          ctrl_q <= '0;
      else if (ctrl_we_i)                   ctrl_q <= wdata_i & KEEP_MASK;
      else if (hit && !ctrl_q[BIT_AUTO])    ctrl_q[BIT_START] <= 1'b0;
      if (srst_wr)           preload_q <= '0;
      else if (preload_we_i) preload_q <= wdata_i[CNT_W-1:0];
      if (srst_wr)         flag_q <= 1'b0;
      else if (hit)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  pre_timer_div #(.PSC_W(PSC_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (srst_wr || start_rise),
    .run_i  (run),
    .psc_i  (ctrl_q[PSC_LSB +: PSC_W]),
    .tick_o (tick)
  );

  pre_timer_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (srst_wr),
    .load_i    (start_rise),
    .load_up_i (wdata_i[BIT_UP]),
    .tick_i    (tick),
    .up_i      (ctrl_q[BIT_UP]),
    .auto_i    (ctrl_q[BIT_AUTO]),
    .preload_i (preload_q),
    .count_o   (count_o),
    .hit_o     (hit)
  );

  assign ctrl_o    = ctrl_q | (CTRL_W'(srst_q) << BIT_SRST);
  assign preload_o = preload_q;
  assign flag_o    = flag_q;
  assign irq_o     = flag_q && ctrl_q[BIT_IRQ];
endmodule

// File: rtl/pre_timer_chk.sv
module pre_timer_chk
  import pre_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic              preload_we_i,
  input logic              flag_clr_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              flag_o,
  input logic              irq_o
);
  p_srst_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[BIT_SRST] && !ctrl_we_i |=> !ctrl_o[BIT_SRST]);

  p_srst_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[BIT_SRST] |-> (count_o == '0) && !flag_o);

  p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[BIT_EN] && !ctrl_we_i |=> $stable(count_o));

  p_up_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[BIT_EN] && ctrl_o[BIT_START] && ctrl_o[BIT_UP] && !ctrl_we_i && !preload_we_i
    |=> (count_o == $past(count_o)) || (count_o == CNT_W'($past(count_o) + CNT_W'(1)))
        || (count_o == '0));

  p_stop_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[BIT_START]) && !$past(ctrl_we_i) |-> flag_o);

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o && ctrl_o[BIT_IRQ]);

  p_flag_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i && !ctrl_we_i |=> flag_o);
endmodule

bind pre_timer pre_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .preload_we_i (preload_we_i),
  .flag_clr_i   (flag_clr_i),
  .ctrl_o       (ctrl_o),
  .count_o      (count_o),
  .flag_o       (flag_o),
  .irq_o        (irq_o)
);

// File: tb/test_pre_timer.sv
`timescale 1ns/1ps
module test_pre_timer;
  localparam int unsigned CW = 8;
  localparam int unsigned PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_we = 1'b0, pre_we = 1'b0, flag_clr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   ctrl_rd;
  logic [CW-1:0] pre_rd, count;
  logic          flag, irq;
  int            n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pre_timer #(.CNT_W(CW), .PSC_W(PW)) i_pre_timer (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .preload_we_i(pre_we),
    .wdata_i(wdata), .flag_clr_i(flag_clr), .ctrl_o(ctrl_rd), .preload_o(pre_rd),
    .count_o(count), .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input bit en, input bit st, input bit up,
                                     input bit au, input bit ie, input int psc);
    return {8'h00, 8'(psc), 10'h000, 1'b0, ie, au, up, st, en};
  endfunction

  // all tasks start and end at a negedge
  task automatic wr_ctrl(input logic [31:0] v);
    ctrl_we = 1'b1; wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_pre(input int v);
    pre_we = 1'b1; wdata = 32'(v);
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_up(input int psc, input int p, input bit au, input int n, input string tag);
    wr_ctrl(32'h20);
    wr_pre(p);
    wr_ctrl(cw(1, 1, 1, au, 0, psc));
    for (int j = 0; j <= n; j++) begin
      int k = j / (psc + 1);
      int ec = au ? (k % (p + 1)) : ((k <= p) ? k : p);
      if (j == 0) chk("R3 up load", count, 0);
      chk({tag, " count"}, count, ec);
      chk({tag, " flag"}, flag, (k > p) ? 1 : 0);
      chk({tag, " start"}, ctrl_rd[1], (au || k <= p) ? 1 : 0);
      step(1);
    end
  endtask

  task automatic run_dn(input int psc, input int p, input bit au, input int n, input string tag);
    wr_ctrl(32'h20);
    wr_pre(p);
    wr_ctrl(cw(1, 1, 0, au, 0, psc));
    for (int j = 0; j <= n; j++) begin
      int k = j / (psc + 1);
      int ec = au ? (p - (k % (p + 1))) : ((k <= p) ? (p - k) : 0);
      if (j == 0) chk("R3 down load", count, p);
      chk({tag, " count"}, count, ec);
      chk({tag, " flag"}, flag, (k > p) ? 1 : 0);
      chk({tag, " start"}, ctrl_rd[1], (au || k <= p) ? 1 : 0);
      step(1);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 ctrl", ctrl_rd, 0);
    chk("R1 preload", pre_rd, 0);
    chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);

    // R2 rate at several prescales, R4 wrap at all ones
    run_up(0, 255, 1, 600, "R4 wrap");
    run_up(1, 255, 1, 600, "R2 psc1");
    run_up(47, 255, 1, 48 * 12, "R2 psc47");
    run_up(0, 0, 1, 10, "R4 p0");
    run_up(2, 9, 1, 80, "R4 p9");
    run_up(1, 5, 0, 30, "R5 stop");
    run_dn(0, 4, 1, 30, "R6 auto");
    run_dn(2, 3, 0, 30, "R6 stop");
    run_dn(0, 0, 1, 5, "R6 p0");

    // R7 freeze and resume with prescale 2
    wr_ctrl(32'h20);
    wr_pre(255);
    wr_ctrl(cw(1, 1, 1, 1, 0, 2));
    step(10);
    wr_ctrl(cw(0, 1, 1, 1, 0, 2));   // this edge still counts: 11 enabled edges
    for (int i = 0; i < 20; i++) begin
      chk("R7 frozen", count, 3);
      step(1);
    end
    wr_ctrl(cw(1, 1, 1, 1, 0, 2));   // no reload, start already set
    for (int m = 0; m <= 12; m++) begin
      chk("R7 resume", count, (11 + m) / 3);
      step(1);
    end

    // R3 restart after stop reloads zero
    wr_ctrl(cw(1, 0, 1, 1, 0, 2));
    chk("R3 start clear", ctrl_rd[1], 0);
    wr_ctrl(cw(1, 1, 1, 1, 0, 2));
    chk("R3 reload", count, 0);

    // R8 soft reset with other bits set
    step(20);
    wr_ctrl(32'h00FF_003F);
    chk("R8 ctrl pulse", ctrl_rd, 32'h20);
    chk("R8 count", count, 0);
    chk("R8 preload", pre_rd, 0);
    chk("R8 flag", flag, 0);
    step(1);
    chk("R8 self clear", ctrl_rd, 0);
    step(5);
    chk("R8 stays idle", count, 0);

    // R9 interrupt gating and flag clear
    wr_pre(2);
    wr_ctrl(cw(1, 1, 1, 0, 1, 0));
    step(5);
    chk("R9 flag", flag, 1);
    chk("R9 irq", irq, 1);
    chk("R9 held count", count, 2);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    chk("R9 flag cleared", flag, 0);
    chk("R9 irq cleared", irq, 0);
    wr_ctrl(32'h20);
    wr_pre(2);
    wr_ctrl(cw(1, 1, 1, 1, 0, 0));
    step(7);
    chk("R9 masked count", count, 1);
    chk("R9 masked flag", flag, 1);
    chk("R9 masked irq", irq, 0);

    summary();
    $finish;
  end
endmodule